// File: doc/BRIEF.md
# Majority-Voting Asynchronous Serial Frame Receiver

This block takes in asynchronous serial frames of ten bits: a low start bit, eight data bits sent least-significant first, and a stop bit. It samples the line only on an external sample tick that runs at sixteen times the bit rate, so each bit lasts sixteen tick-counter states. The line first passes through a two-flop synchronizer. While the receiver is idle it looks for a high-to-low change between two consecutive ticks. When it finds one, it realigns its phase counter at once. Each bit is then decided by a two-of-three vote over the samples at counter states 7, 8 and 9.

A start bit that votes high is treated as noise, and the receiver goes back to waiting. At the vote of the stop bit the frame is finished. The byte and the stop bit are copied into the holding registers, and the receive flag is raised, only if two conditions hold. First, the flag must be clear. Second, either the address-filter enable is off or the stop bit voted 1. If either condition fails, the frame is dropped without trace. The flag stays up until the host pulses the clear strobe.

The controller has four states: IDLE, START, DATA and STOP. Its transitions are:
- `edge_seen`: IDLE to START on a detected falling edge.
- `start_bad`: START to IDLE when the start bit votes 1.
- `start_ok`: START to DATA when the start bit votes 0.
- `data_next`: DATA to DATA on each data-bit vote except the last.
- `data_last`: DATA to STOP on the eighth data-bit vote.
- `stop_done`: STOP to IDLE on the stop-bit vote.

Top module: `uart_mv_rx`

## Requirements
- R1: After reset, `rx_data` is 0x00, `rx_stop` is 0 and `rx_flag` is 0.
- R2: The line is examined only in cycles where `sample_tick` is 1. A frame starts only when the synchronized line is 1 at one tick and 0 at the next tick. A low pulse that falls and rises between two ticks starts nothing.
- R3: Counter state 0 is the tick that detects the edge, and each later tick advances the state by one. Each bit takes the majority of the samples at states 7, 8 and 9. A single deviating sample among those three does not change the bit. Two deviating samples at states 7 and 8 invert the bit. Deviations at states 6 and 10 have no effect.
- R4: If the start bit votes 1, the receiver returns to IDLE without touching the outputs, and a later valid frame is received normally.
- R5: The first data bit after the start bit becomes `rx_data[0]`, and the last one becomes `rx_data[7]`.
- R6: At the stop-bit vote, if `rx_flag` is 0 and either `addr_filt_en` is 0 or the stop bit is 1, the byte goes to `rx_data`, the stop bit goes to `rx_stop`, and `rx_flag` becomes 1.
- R7: At the stop-bit vote, if `rx_flag` is already 1, the frame is dropped and `rx_data`, `rx_stop` and `rx_flag` keep their values.
- R8: If `addr_filt_en` is 1 and the stop bit votes 0, the frame is dropped and all outputs keep their values.
- R9: A one-cycle `flag_clr` pulse clears `rx_flag`. If a load and `flag_clr` occur in the same cycle, `rx_flag` ends up 1.
- R10: The receiver returns to IDLE at the stop-bit vote, at state 9. A new start edge that comes right after that tick is received.
- R11: When `addr_filt_en` is 0, a frame whose stop bit votes 0 is still loaded, and `rx_stop` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| addr_filt_en | input | 1 | When 1, only frames with a stop bit of 1 are accepted |
| flag_clr | input | 1 | Strobe that clears the receive flag |
| rx_data | output | 8 | Received byte holding register |
| rx_stop | output | 1 | Received stop-bit register |
| rx_flag | output | 1 | Receive-complete flag |

## Verification
The hardest cases to reach from the ports are those that depend on the exact internal counter state. One is a load that coincides with a host clear. The other is a line disturbance placed on particular vote states. The bench drives the line one tick period at a time, with a fixed offset from the tick, so each counter state maps to a known tick after the falling edge. This lets it corrupt samples exactly at states 7 and 8, or at states 6 and 10. To create the same-cycle case, it holds `flag_clr` high through stop-bit states 0 to 9, so the clear is active in the cycle of the load.

// File: rtl/uart_mv_rx_pkg.sv
package uart_mv_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_mv_rx_sync.sv
module uart_mv_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_mv_rx_voter.sv
module uart_mv_rx_voter
    import uart_mv_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line,
    input  logic align,
    input  logic run,
    output logic vote_strobe,
    output logic vote_bit
);
    localparam int PW = $clog2(OVS);
    localparam int VA = OVS / 2 - 1;
    localparam int VB = OVS / 2;
    localparam int VC = OVS / 2 + 1;

    logic [PW-1:0] phase_q;
    logic          samp_a_q;
    logic          samp_b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q  <= '0;
            samp_a_q <= 1'b1;
            samp_b_q <= 1'b1;
        end else if (tick) begin
            if (align) begin
                phase_q <= PW'(1);
            end else if (run) begin
                phase_q <= (phase_q == PW'(OVS - 1)) ? '0 : phase_q + PW'(1);
            end
            if (run && phase_q == PW'(VA)) begin
                samp_a_q <= line;
            end
            if (run && phase_q == PW'(VB)) begin
                samp_b_q <= line;
            end
        end
    end

    assign vote_strobe = tick && run && (phase_q == PW'(VC));
    assign vote_bit    = maj3(samp_a_q, samp_b_q, line);
endmodule

// File: rtl/uart_mv_rx_hold.sv
module uart_mv_rx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_done,
    input  logic [DW-1:0] frame_data,
    input  logic          frame_stop,
    input  logic          addr_filt_en,
    input  logic          flag_clr,
    output logic [DW-1:0] hold_data,
    output logic          hold_stop,
    output logic          hold_flag
);
    logic accept;

    assign accept = frame_done && !hold_flag && (!addr_filt_en || frame_stop);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_stop <= 1'b0;
            hold_flag <= 1'b0;
        end else begin
            if (accept) begin
                hold_data <= frame_data;
                hold_stop <= frame_stop;
            end
            if (accept) begin
                hold_flag <= 1'b1;
            end else if (flag_clr) begin
                hold_flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uart_mv_rx.sv
module uart_mv_rx
    import uart_mv_rx_pkg::*;
#(
    parameter int DW          = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_tick,
    input  logic          rx_line,
    input  logic          addr_filt_en,
    input  logic          flag_clr,
    output logic [DW-1:0] rx_data,
    output logic          rx_stop,
    output logic          rx_flag
);
    localparam int CW = $clog2(DW + 1);

    rx_state_e     state_q, state_d;
    logic          line_s;
    logic          prev_q;
    logic          fall;
    logic          align;
    logic          run;
    logic          vote_strobe;
    logic          vote_bit;
    logic          frame_done;
    logic [DW-1:0] shift_q;
    logic [CW-1:0] bit_cnt_q;

    uart_mv_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (line_s)
    );

    assign fall  = sample_tick && prev_q && !line_s;
    assign align = (state_q == RX_IDLE) && fall;
    assign run   = (state_q != RX_IDLE);

    uart_mv_rx_voter #(.OVS(OVS)) u_voter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (sample_tick),
        .line       (line_s),
        .align      (align),
        .run        (run),
        .vote_strobe(vote_strobe),
        .vote_bit   (vote_bit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if (fall) state_d = RX_START;                     // edge_seen
            end
            RX_START: begin
                if (vote_strobe) begin
                    state_d = vote_bit ? RX_IDLE : RX_DATA;       // start_bad / start_ok
                end
            end
            RX_DATA: begin
                if (vote_strobe && bit_cnt_q == CW'(DW - 1)) begin
                    state_d = RX_STOP;                            // data_last
                end
            end
            RX_STOP: begin
                if (vote_strobe) state_d = RX_IDLE;               // stop_done
            end
            default: state_d = RX_IDLE;
        endcase
    end

    // datapath driven by state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q    <= 1'b1;
            shift_q   <= '0;
            bit_cnt_q <= '0;
        end else begin
            if (sample_tick) begin
                prev_q <= line_s;
            end
            if (align) begin
                bit_cnt_q <= '0;
            end else if (state_q == RX_DATA && vote_strobe) begin
                shift_q   <= {vote_bit, shift_q[DW-1:1]};
                bit_cnt_q <= bit_cnt_q + CW'(1);
            end
        end
    end

    assign frame_done = (state_q == RX_STOP) && vote_strobe;

    uart_mv_rx_hold #(.DW(DW)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_done  (frame_done),
        .frame_data  (shift_q),
        .frame_stop  (vote_bit),
        .addr_filt_en(addr_filt_en),
        .flag_clr    (flag_clr),
        .hold_data   (rx_data),
        .hold_stop   (rx_stop),
        .hold_flag   (rx_flag)
    );
endmodule

// File: rtl/uart_mv_rx_chk.sv
module uart_mv_rx_chk
    import uart_mv_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          addr_filt_en,
    input logic          flag_clr,
    input logic [DW-1:0] rx_data,
    input logic          rx_stop,
    input logic          rx_flag,
    input rx_state_e     state_q,
    input logic          fall,
    input logic          vote_strobe,
    input logic          vote_bit
);
    // R2
    idle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_IDLE && !fall) |=> (state_q == RX_IDLE));

    // R4
    false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_START && vote_strobe && vote_bit) |=> (state_q == RX_IDLE));

    // R6
    load_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_STOP && vote_strobe && !rx_flag && (!addr_filt_en || vote_bit))
        |=> (rx_flag && rx_stop == $past(vote_bit)));

    // R7
    drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_STOP && vote_strobe && rx_flag)
        |=> ($stable(rx_data) && $stable(rx_stop) && rx_flag));

    // R7
    no_stray_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == RX_STOP && vote_strobe) |=> ($stable(rx_data) && $stable(rx_stop)));

    // R8
    filter_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_STOP && vote_strobe && addr_filt_en && !vote_bit)
        |=> ($stable(rx_data) && $stable(rx_stop)));

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(state_q == RX_STOP && vote_strobe)) |=> !rx_flag);

    // R10
    stop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_STOP && vote_strobe) |=> (state_q == RX_IDLE));
endmodule

bind uart_mv_rx uart_mv_rx_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_filt_en(addr_filt_en),
    .flag_clr    (flag_clr),
    .rx_data     (rx_data),
    .rx_stop     (rx_stop),
    .rx_flag     (rx_flag),
    .state_q     (state_q),
    .fall        (fall),
    .vote_strobe (vote_strobe),
    .vote_bit    (vote_bit)
);

// File: tb/uart_mv_rx_tb.sv
module uart_mv_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;

    // vector: data[12:5], stop[4], filt[3], preclr[2], glitch mode[1:0]
    // glitch mode on frame bit 3 (data bit 2): 0 none, 1 state 8, 2 states 7+8, 3 states 6+10
    localparam logic [12:0] VEC [NVEC] = '{
        {8'hA5, 1'b1, 1'b0, 1'b1, 2'd0},
        {8'h3C, 1'b1, 1'b0, 1'b0, 2'd0},
        {8'h3C, 1'b1, 1'b0, 1'b1, 2'd1},
        {8'h3C, 1'b1, 1'b0, 1'b1, 2'd2},
        {8'h81, 1'b1, 1'b0, 1'b1, 2'd3},
        {8'h5A, 1'b0, 1'b1, 1'b1, 2'd0},
        {8'h5A, 1'b1, 1'b1, 1'b1, 2'd0},
        {8'hC3, 1'b0, 1'b0, 1'b1, 2'd0},
        {8'h01, 1'b1, 1'b0, 1'b1, 2'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic       addr_filt_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_stop;
    logic       rx_flag;

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_data = 8'h00;
    logic       exp_stop = 1'b0;
    logic       exp_flag = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_mv_rx u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (sample_tick),
        .rx_line     (rx_line),
        .addr_filt_en(addr_filt_en),
        .flag_clr    (flag_clr),
        .rx_data     (rx_data),
        .rx_stop     (rx_stop),
        .rx_flag     (rx_flag)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " rx_flag"}, {7'd0, rx_flag}, {7'd0, exp_flag});
        chk({tag, " rx_data"}, rx_data, exp_data);
        chk({tag, " rx_stop"}, {7'd0, rx_stop}, {7'd0, exp_stop});
    endtask

    // one tick period: c = 0 none, 1 one-cycle clear pulse, 2 clear held through the tick
    task automatic period(input logic v, input int c);
        rx_line  = v;
        flag_clr = (c != 0);
        @(negedge clk);
        if (c != 2) flag_clr = 1'b0;
        repeat (2) @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
    endtask

    task automatic idle_periods(input int n);
        for (int i = 0; i < n; i++) period(1'b1, 0);
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        exp_flag = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input logic stp, input int mode,
                              input int stop_ticks, input bit clr_start, input bit hold_stop_clr);
        for (int b = 0; b < 10; b++) begin
            logic bv;
            int   n;
            bv = (b == 0) ? 1'b0 : (b == 9) ? stp : d[b-1];
            n  = (b == 9) ? stop_ticks : 16;
            for (int s = 0; s < n; s++) begin
                logic v;
                int   c;
                v = bv;
                if (b == 3 && ((mode == 1 && s == 8) ||
                               (mode == 2 && (s == 7 || s == 8)) ||
                               (mode == 3 && (s == 6 || s == 10)))) v = ~bv;
                c = 0;
                if (b == 0 && s == 0 && clr_start) c = 1;
                if (b == 9 && s <= 9 && hold_stop_clr) c = 2;
                period(v, c);
            end
        end
        flag_clr = 1'b0;
    endtask

    task automatic model_frame(input logic [7:0] d, input logic stp, input logic filt);
        if (!exp_flag && (!filt || stp)) begin
            exp_data = d;
            exp_stop = stp;
            exp_flag = 1'b1;
        end
    endtask

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R6 R5 vec0";
            1: return "R7 vec1";
            2: return "R3 single glitch vec2";
            3: return "R3 double glitch vec3";
            4: return "R3 outside window vec4";
            5: return "R8 vec5";
            6: return "R6 filter on vec6";
            7: return "R11 vec7";
            default: return "R5 lsb first vec8";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;
        idle_periods(4);
        check_all("R1 after release");

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] d;
            logic       stp, filt, pre;
            int         mode;
            d    = VEC[i][12:5];
            stp  = VEC[i][4];
            filt = VEC[i][3];
            pre  = VEC[i][2];
            mode = int'(VEC[i][1:0]);
            addr_filt_en = filt;
            if (pre) pulse_clr();
            send_frame(d, stp, mode, 16, 1'b0, 1'b0);
            idle_periods(4);
            model_frame((mode == 2) ? (d ^ 8'h04) : d, stp, filt);
            check_all(vec_tag(i));
        end
        addr_filt_en = 1'b0;

        // R4: false start then a valid frame
        pulse_clr();
        for (int i = 0; i < 4; i++) period(1'b0, 0);
        idle_periods(30);
        check_all("R4 false start ignored");
        send_frame(8'h6E, 1'b1, 0, 16, 1'b0, 1'b0);
        idle_periods(4);
        model_frame(8'h6E, 1'b1, 1'b0);
        check_all("R4 recovery frame");

        // R2: low pulse between ticks is not seen
        pulse_clr();
        rx_line = 1'b0;
        repeat (2) @(negedge clk);
        rx_line = 1'b1;
        repeat (3) @(negedge clk);
        idle_periods(200);
        check_all("R2 low between ticks");

        // R9: load and clear in the same cycle, set wins
        pulse_clr();
        send_frame(8'h97, 1'b1, 0, 16, 1'b0, 1'b1);
        idle_periods(4);
        model_frame(8'h97, 1'b1, 1'b0);
        check_all("R9 set beats clear");
        pulse_clr();
        @(negedge clk);
        check_all("R9 clear alone");

        // R10: stop bit cut to states 0..9, next start follows at once
        send_frame(8'h12, 1'b1, 0, 10, 1'b0, 1'b0);
        model_frame(8'h12, 1'b1, 1'b0);
        send_frame(8'hE4, 1'b1, 0, 16, 1'b1, 1'b0);
        exp_flag = 1'b0;
        idle_periods(4);
        model_frame(8'hE4, 1'b1, 1'b0);
        check_all("R10 back-to-back");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule